// File: doc/BRIEF.md
# Bypassable Linear Neighbour Network

This block joins a row of processing elements into a one-dimensional chain that can be reshaped every cycle. Each element presents an outgoing word and a bypass bit. An element with its bypass bit clear is a member of the chain. An element with its bypass bit set is spliced out: words pass through its switch untouched, and it takes no part in the exchange. Elements that are neighbours in the chain can therefore sit far apart in the physical row. The usual source of the bypass bits is the responder status of an associative search, with non-responders bypassed. After such a search, one shift carries a word between the nearest responders.

A transfer is requested by one strobe and one direction bit, both shared by every element. In the from-lower direction, each member latches the word of the nearest member with a smaller index. In the from-higher direction, each member latches the word of the nearest member with a larger index. A member that has no such member on the requested side latches zero and raises a no-source flag. The received words are registered, so they are ready as execute-stage operands in the cycle after the strobe. The pass-through path is combinational across the whole row, so its delay grows with the element count.

Top module: `lnet_top`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, every received word and every no-source flag becomes 0.
- R2: When `xfer_valid` is 1 and `shift_dir` is 1 (from lower), each non-bypassed element i latches `pe_out` of the non-bypassed element with the largest index below i, and clears its no-source flag.
- R3: When `xfer_valid` is 1 and `shift_dir` is 0 (from higher), each non-bypassed element i latches `pe_out` of the non-bypassed element with the smallest index above i, and clears its no-source flag.
- R4: A non-bypassed element that has no non-bypassed element on the requested side latches 0 and sets its no-source flag. A set no-source flag always comes with a received word of 0.
- R5: An element whose `bypass` bit is 1 during a transfer keeps its received word and its no-source flag unchanged.
- R6: The `pe_out` word of a bypassed element never reaches any element's received word.
- R7: In a cycle with `xfer_valid` at 0, every received word and every no-source flag holds its value, whatever the other inputs do.
- R8: Outputs are registered. A transfer sampled at a clock edge shows on the outputs only after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | Perform a transfer at this edge |
| shift_dir | input | 1 | 1: receive from lower side, 0: receive from higher side |
| bypass | input | NUM_PE | Bit i set removes element i from the chain |
| pe_out | input | NUM_PE*DATA_W | Outgoing word of element i in bits [i*DATA_W +: DATA_W] |
| rx_data | output | NUM_PE*DATA_W | Registered received word of element i, same packing |
| rx_none | output | NUM_PE | Registered no-source flag of element i |

## Verification
The assertions assume that `bypass` and `shift_dir` are settled at the edge where `xfer_valid` is sampled, and that they stay meaningful for that edge only. They assume nothing about the pattern of members. The stimulus drives every input at the falling edge, sweeps every bypass pattern of a six-element row in both directions, and gives bypassed elements distinctive junk words, so any leak of those words shows up. Idle cycles change all the data inputs while the strobe stays low.

// File: rtl/lnet_pkg.sv
package lnet_pkg;
  typedef enum logic {
    DIR_FROM_HIGH = 1'b0,
    DIR_FROM_LOW  = 1'b1
  } dir_e;
endpackage

// File: rtl/lnet_node.sv
// Per-element switch: forwards either its own word or the word passing through.
module lnet_node
  import lnet_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              bypass,
  input  logic [DATA_W-1:0] own_data,
  input  logic              dir,
  input  logic              lo_vld,
  input  logic [DATA_W-1:0] lo_data,
  input  logic              hi_vld,
  input  logic [DATA_W-1:0] hi_data,
  output logic              up_vld,
  output logic [DATA_W-1:0] up_data,
  output logic              dn_vld,
  output logic [DATA_W-1:0] dn_data,
  output logic              rx_vld,
  output logic [DATA_W-1:0] rx_word
);
  always_comb begin
    if (bypass) begin
      up_vld  = lo_vld;
      up_data = lo_data;
      dn_vld  = hi_vld;
      dn_data = hi_data;
    end else begin
      up_vld  = 1'b1;
      up_data = own_data;
      dn_vld  = 1'b1;
      dn_data = own_data;
    end
  end

  always_comb begin
    if (dir_e'(dir) == DIR_FROM_LOW) begin
      rx_vld  = lo_vld;
      rx_word = lo_vld ? lo_data : '0;
    end else begin
      rx_vld  = hi_vld;
      rx_word = hi_vld ? hi_data : '0;
    end
  end
endmodule

// File: rtl/lnet_chain.sv
// Combinational ripple of switches in both directions across the row.
module lnet_chain #(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 8,
  localparam int BUS_W = NUM_PE * DATA_W
) (
  input  logic [NUM_PE-1:0] bypass,
  input  logic [BUS_W-1:0]  pe_out,
  input  logic              dir,
  output logic [BUS_W-1:0]  rx_word,
  output logic [NUM_PE-1:0] rx_vld
);
  logic [NUM_PE:0]   up_v;
  logic [DATA_W-1:0] up_d [NUM_PE+1];
  logic [NUM_PE:0]   dn_v;
  logic [DATA_W-1:0] dn_d [NUM_PE+1];

  assign up_v[0]      = 1'b0;
  assign up_d[0]      = '0;
  assign dn_v[NUM_PE] = 1'b0;
  assign dn_d[NUM_PE] = '0;

  for (genvar i = 0; i < NUM_PE; i++) begin : g_node
    lnet_node #(.DATA_W(DATA_W)) u_node (
      .bypass  (bypass[i]),
      .own_data(pe_out[i*DATA_W +: DATA_W]),
      .dir     (dir),
      .lo_vld  (up_v[i]),
      .lo_data (up_d[i]),
      .hi_vld  (dn_v[i+1]),
      .hi_data (dn_d[i+1]),
      .up_vld  (up_v[i+1]),
      .up_data (up_d[i+1]),
      .dn_vld  (dn_v[i]),
      .dn_data (dn_d[i]),
      .rx_vld  (rx_vld[i]),
      .rx_word (rx_word[i*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/lnet_top.sv
module lnet_top #(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 8,
  localparam int BUS_W = NUM_PE * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_valid,
  input  logic              shift_dir,
  input  logic [NUM_PE-1:0] bypass,
  input  logic [BUS_W-1:0]  pe_out,
  output logic [BUS_W-1:0]  rx_data,
  output logic [NUM_PE-1:0] rx_none
);
  logic [BUS_W-1:0]  net_word;
  logic [NUM_PE-1:0] net_vld;

  lnet_chain #(.NUM_PE(NUM_PE), .DATA_W(DATA_W)) u_chain (
    .bypass (bypass),
    .pe_out (pe_out),
    .dir    (shift_dir),
    .rx_word(net_word),
    .rx_vld (net_vld)
  );

  for (genvar i = 0; i < NUM_PE; i++) begin : g_rx
    always_ff @(posedge clk) begin
      if (rst) begin
        rx_data[i*DATA_W +: DATA_W] <= '0;
        rx_none[i]                  <= 1'b0;
      end else if (xfer_valid && !bypass[i]) begin
        rx_data[i*DATA_W +: DATA_W] <= net_word[i*DATA_W +: DATA_W];
        rx_none[i]                  <= !net_vld[i];
      end
    end
  end
endmodule

// File: rtl/lnet_checker.sv
module lnet_checker #(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 8,
  localparam int BUS_W = NUM_PE * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_valid,
  input logic              shift_dir,
  input logic [NUM_PE-1:0] bypass,
  input logic [BUS_W-1:0]  rx_data,
  input logic [NUM_PE-1:0] rx_none
);
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !xfer_valid |=> ($stable(rx_data) && $stable(rx_none)));

  a_r4_first_no_src: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && shift_dir && !bypass[0]) |=> rx_none[0]);

  a_r4_last_no_src: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !shift_dir && !bypass[NUM_PE-1]) |=> rx_none[NUM_PE-1]);

  for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
    a_r5_bypass_hold: assert property (@(posedge clk) disable iff (rst)
      (xfer_valid && bypass[i]) |=>
        ($stable(rx_data[i*DATA_W +: DATA_W]) && $stable(rx_none[i])));

    a_r4_none_zero: assert property (@(posedge clk) disable iff (rst)
      rx_none[i] |-> (rx_data[i*DATA_W +: DATA_W] == '0));
  end
endmodule

bind lnet_top lnet_checker #(.NUM_PE(NUM_PE), .DATA_W(DATA_W)) u_lnet_chk (
  .clk       (clk),
  .rst       (rst),
  .xfer_valid(xfer_valid),
  .shift_dir (shift_dir),
  .bypass    (bypass),
  .rx_data   (rx_data),
  .rx_none   (rx_none)
);

// File: tb/lnet_top_bench.sv
module lnet_top_bench;
  localparam int N = 6;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           xfer_valid = 1'b0;
  logic           shift_dir = 1'b0;
  logic [N-1:0]   bypass = '0;
  logic [N*W-1:0] pe_out = '0;
  logic [N*W-1:0] rx_data;
  logic [N-1:0]   rx_none;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] exp_d [N];
  logic         exp_n [N];

  always #10 clk = ~clk;

  lnet_top #(.NUM_PE(N), .DATA_W(W)) u_lnet_top (
    .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .shift_dir(shift_dir),
    .bypass(bypass), .pe_out(pe_out), .rx_data(rx_data), .rx_none(rx_none)
  );

  function automatic logic [W-1:0] word_of(int i, int pat, int dir, int bp);
    if (bp != 0) return W'(8'hA0 | i);
    return W'(i * 37 + pat * 5 + dir * 91 + 3);
  endfunction

  task automatic check_all(string req);
    for (int i = 0; i < N; i++) begin
      checks++;
      if (rx_data[i*W +: W] !== exp_d[i] || rx_none[i] !== exp_n[i]) begin
        errors++;
        $display("FAIL %s pe%0d: got data=%h none=%b, expected data=%h none=%b",
                 req, i, rx_data[i*W +: W], rx_none[i], exp_d[i], exp_n[i]);
      end
    end
  endtask

  // Reference: ordered list of member indices, each member's source is its list neighbour.
  task automatic do_xfer(int pat, int dir);
    int act [N];
    int cnt = 0;
    @(negedge clk);
    bypass    = N'(pat);
    shift_dir = dir[0];
    for (int i = 0; i < N; i++)
      pe_out[i*W +: W] = word_of(i, pat, dir, int'(bypass[i])); // R6: junk on bypassed
    xfer_valid = 1'b1;
    #5;
    check_all("R8"); // nothing moves before the edge
    for (int i = 0; i < N; i++)
      if (!bypass[i]) begin act[cnt] = i; cnt++; end
    for (int k = 0; k < cnt; k++) begin
      int src = (dir == 1) ? k - 1 : k + 1;
      if (src < 0 || src >= cnt) begin
        exp_d[act[k]] = '0; exp_n[act[k]] = 1'b1;
      end else begin
        exp_d[act[k]] = word_of(act[src], pat, dir, 0); exp_n[act[k]] = 1'b0;
      end
    end
    @(negedge clk);
    xfer_valid = 1'b0;
    // R2 / R3 / R4 for members, R5 for bypassed, R6 via junk words
    check_all(dir == 1 ? "R2_R4_R5_R6" : "R3_R4_R5_R6");
  endtask

  initial begin : watchdog
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin exp_d[i] = '0; exp_n[i] = 1'b0; end
    pe_out = {N{8'h5C}};
    repeat (3) @(negedge clk);
    check_all("R1");
    rst = 1'b0;
    for (int pat = 0; pat < (1 << N); pat++)
      for (int dir = 0; dir < 2; dir++)
        do_xfer(pat, dir);
    // R7: idle cycles with churning inputs
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      bypass    = N'(c * 11);
      shift_dir = c[0];
      for (int i = 0; i < N; i++) pe_out[i*W +: W] = W'(c * 29 + i);
      @(negedge clk);
      check_all("R7");
    end
    // R1 again: reset mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    xfer_valid = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    xfer_valid = 1'b0;
    for (int i = 0; i < N; i++) begin exp_d[i] = '0; exp_n[i] = 1'b0; end
    check_all("R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule